// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address within one clock. A request is checked against a fixed order of rules. A privileged-code fetch, marked by bit 0 of the program counter, passes straight through. An address whose upper bits are not a proper sign extension is rejected. A kernel-only direct-mapped window, when enabled, bypasses the page table. Every other address is looked up in an external translation buffer through a combinational lookup port, and the execute permission of the current privilege mode is checked on the entry that matches.

The result is registered. It carries the physical address, an uncacheable flag taken from the top implemented physical address bit, and a fault code. When a fault occurs, the block keeps the faulting program counter. It also forms a pointer into the virtual page table by merging the table base with the virtual page number shifted left by three. Single-cycle hit, miss and violation pulses feed external event counters. Refill of the buffer and the registers that configure the block belong to the surrounding core.

Top module: `ifetch_xlate`

## Requirements
- R1: When `req_pc[0]` is 1, the response has fault code 0 (none), `rsp_paddr` equals `req_pc[PA_W-1:0]` with bits 1:0 cleared, `rsp_uncached` is 0, and no lookup is issued. This rule ranks above every other rule.
- R2: If R1 does not apply and `req_pc[63:42]` is not all zeros or all ones, the fault code is 1 (access violation).
- R3: When `sp_en[1]` is 1, `req_pc[42:41]` is 2'b10 and `cur_mode` is 0 (kernel), `rsp_paddr` equals `req_pc[PA_W-1:0]`, the fault code is 0, and no lookup is issued.
- R4: In the direct-mapped window of R3, any `cur_mode` other than 0 gives fault code 1.
- R5: When a lookup is issued and `tlb_hit` is 0, the fault code is 2 (miss) and `ev_miss` pulses.
- R6: When the lookup hits and `tlb_xen[cur_mode]` is 0, the fault code is 1. Modes are 0 kernel, 1 executive, 2 supervisor and 3 user, and `tlb_xen` holds one enable bit per mode.
- R7: On a permitted hit, `rsp_paddr` is `{tlb_pfn, req_pc[12:2], 2'b00}`, which gives 8 KB pages.
- R8: On any fault, `flt_tag` takes `req_pc` and `flt_ptr` takes `ptbase | (req_pc[42:13] << 3)`. Both hold their values when there is no fault.
- R9: A fault-free response from the direct-mapped window or from a lookup sets `rsp_uncached` equal to `rsp_paddr[PA_W-1]`.
- R10: The response appears one cycle after `req_valid`, with `rsp_valid` high and exactly one of `ev_hit`, `ev_acv` and `ev_miss` pulsing. On a fault, `rsp_paddr` is 0 and `rsp_uncached` is 0.
- R11: After reset, `rsp_valid`, all event pulses, `flt_tag` and `flt_ptr` are 0.
- R12: A lookup raises `tlb_req` in the request cycle, with `tlb_vpn` = `req_pc[42:13]` and `tlb_asn` = `cur_asn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request strobe |
| req_pc | input | VA_W | Fetch virtual address; bit 0 marks privileged code |
| sp_en | input | 2 | Direct-window enables; bit 1 enables the window |
| cur_mode | input | 2 | Current privilege mode |
| cur_asn | input | ASN_W | Current address space number |
| ptbase | input | VA_W | Virtual page table base |
| tlb_req | output | 1 | Lookup strobe |
| tlb_vpn | output | VPN_W | Virtual page number to look up |
| tlb_asn | output | ASN_W | Address space number to look up |
| tlb_hit | input | 1 | Lookup matched, same cycle |
| tlb_pfn | input | PFN_W | Frame number of the matching entry |
| tlb_xen | input | 4 | Per-mode execute enables of the matching entry |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | PA_W | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 2 | 0 none, 1 access violation, 2 miss |
| ev_hit | output | 1 | Successful translation pulse |
| ev_miss | output | 1 | Miss pulse |
| ev_acv | output | 1 | Access violation pulse |
| flt_tag | output | VA_W | Last faulting program counter |
| flt_ptr | output | VA_W | Last fault page-table pointer |

## Verification
The assertions assume that the lookup port answers in the same cycle as `tlb_req`, and that `tlb_pfn` and `tlb_xen` matter only while `tlb_hit` is high. They also assume that the request and the control inputs stay steady from the request edge until they are sampled. The bench applies each request, together with its lookup answer and its control values, on the falling edge. It holds all of them through the following rising edge and reads the registered response on the next falling edge. When no lookup is expected, the bench leaves the answer signals in an arbitrary state, which also shows that they are ignored.

// File: rtl/ifetch_xlate.sv
module ifetch_xlate #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 41,
  parameter int PAGE_W  = 13,
  parameter int ASN_W   = 8,
  localparam int VPN_W  = VA_IMPL - PAGE_W,
  localparam int PFN_W  = PA_W - PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_pc,
  input  logic [1:0]       sp_en,
  input  logic [1:0]       cur_mode,
  input  logic [ASN_W-1:0] cur_asn,
  input  logic [VA_W-1:0]  ptbase,
  output logic             tlb_req,
  output logic [VPN_W-1:0] tlb_vpn,
  output logic [ASN_W-1:0] tlb_asn,
  input  logic             tlb_hit,
  input  logic [PFN_W-1:0] tlb_pfn,
  input  logic [3:0]       tlb_xen,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_uncached,
  output logic [1:0]       rsp_fault,
  output logic             ev_hit,
  output logic             ev_miss,
  output logic             ev_acv,
  output logic [VA_W-1:0]  flt_tag,
  output logic [VA_W-1:0]  flt_ptr
);
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_ACV  = 2'd1;
  localparam logic [1:0] F_MISS = 2'd2;
  localparam int TOP_W = VA_W - VA_IMPL + 1;

  logic            pal, va_ok, spage, kern;
  logic [TOP_W-1:0] top;
  logic [1:0]      code;
  logic [PA_W-1:0] pa;
  logic            unc;

  assign pal     = req_pc[0];
  assign top     = req_pc[VA_W-1:VA_IMPL-1];
  assign va_ok   = (&top) | ~(|top);
  assign spage   = sp_en[1] && (req_pc[VA_IMPL-1 -: 2] == 2'b10);
  assign kern    = (cur_mode == 2'd0);
  assign tlb_vpn = req_pc[VA_IMPL-1:PAGE_W];
  assign tlb_asn = cur_asn;
  assign tlb_req = req_valid && !pal && va_ok && !spage;

  always_comb begin
    code = F_NONE;
    pa   = '0;
    unc  = 1'b0;
    if (pal) begin
      pa = {req_pc[PA_W-1:2], 2'b00};
    end else if (!va_ok) begin
      code = F_ACV;
    end else if (spage) begin
      if (kern) begin
        pa  = req_pc[PA_W-1:0];
        unc = pa[PA_W-1];
      end else begin
        code = F_ACV;
      end
    end else if (!tlb_hit) begin
      code = F_MISS;
    end else if (!tlb_xen[cur_mode]) begin
      code = F_ACV;
    end else begin
      pa  = {tlb_pfn, req_pc[PAGE_W-1:2], 2'b00};
      unc = pa[PA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= F_NONE;
      ev_hit       <= 1'b0;
      ev_miss      <= 1'b0;
      ev_acv       <= 1'b0;
      flt_tag      <= '0;
      flt_ptr      <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_paddr    <= req_valid ? pa : '0;
      rsp_uncached <= req_valid && unc;
      rsp_fault    <= req_valid ? code : F_NONE;
      ev_hit       <= req_valid && (code == F_NONE);
      ev_miss      <= req_valid && (code == F_MISS);
      ev_acv       <= req_valid && (code == F_ACV);
      if (req_valid && code != F_NONE) begin
        flt_tag <= req_pc;
        flt_ptr <= ptbase | (VA_W'(tlb_vpn) << 3);
      end
    end
  end

  assert_pal_nolook_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pc[0]) |-> !tlb_req);
  assert_pal_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pc[0]) |=> (rsp_fault == F_NONE && ev_hit && rsp_paddr[1:0] == 2'b00 && !rsp_uncached));
  assert_miss_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && !tlb_hit) |=> (rsp_fault == F_MISS && ev_miss));
  assert_miss_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && !tlb_hit) |=> (flt_tag == $past(req_pc)));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(flt_tag) && $stable(flt_ptr)));
  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({ev_hit, ev_miss, ev_acv}) == 1 && rsp_fault != 2'd3));
  assert_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(ev_hit || ev_miss || ev_acv));
  assert_fault_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_NONE) |-> (rsp_paddr == '0 && !rsp_uncached));
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/ifetch_xlate_bench.sv
`timescale 1ns/1ps
module ifetch_xlate_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, tlb_req, tlb_hit;
  logic [63:0] req_pc, ptbase, flt_tag, flt_ptr;
  logic [1:0]  sp_en, cur_mode, rsp_fault;
  logic [7:0]  cur_asn, tlb_asn;
  logic [29:0] tlb_vpn;
  logic [27:0] tlb_pfn;
  logic [3:0]  tlb_xen;
  logic        rsp_valid, rsp_uncached, ev_hit, ev_miss, ev_acv;
  logic [40:0] rsp_paddr;

  ifetch_xlate u_ifetch_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
    .sp_en(sp_en), .cur_mode(cur_mode), .cur_asn(cur_asn), .ptbase(ptbase),
    .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(tlb_hit),
    .tlb_pfn(tlb_pfn), .tlb_xen(tlb_xen), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_acv(ev_acv),
    .flt_tag(flt_tag), .flt_ptr(flt_ptr));

  typedef struct packed {
    logic [63:0] pc;
    logic [1:0]  sp;
    logic [1:0]  mode;
    logic        hit;
    logic [27:0] pfn;
    logic [3:0]  xen;
    logic        look;
    logic [1:0]  code;
    logic [40:0] pa;
    logic        unc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0123_4567_89AB, 2'b10, 2'd3, 1'b0, 28'h0, 4'h0, 1'b0, 2'd0, 41'h123_4567_89A8, 1'b0},
    '{64'h8000_0000_0000_0005, 2'b00, 2'd0, 1'b0, 28'h0, 4'h0, 1'b0, 2'd0, 41'h000_0000_0004, 1'b0},
    '{64'h0000_0800_0000_0000, 2'b00, 2'd0, 1'b1, 28'h1, 4'hF, 1'b0, 2'd1, 41'h0, 1'b0},
    '{64'hFFFF_FC00_0012_3450, 2'b10, 2'd0, 1'b0, 28'h0, 4'h0, 1'b0, 2'd0, 41'h000_0012_3450, 1'b0},
    '{64'hFFFF_FD00_0000_2000, 2'b10, 2'd0, 1'b0, 28'h0, 4'h0, 1'b0, 2'd0, 41'h100_0000_2000, 1'b1},
    '{64'hFFFF_FC00_0012_3450, 2'b10, 2'd3, 1'b1, 28'h5, 4'hF, 1'b0, 2'd1, 41'h0, 1'b0},
    '{64'hFFFF_FC00_0012_3450, 2'b01, 2'd0, 1'b1, 28'h0000ABC, 4'b0001, 1'b1, 2'd0, 41'h000_0157_9450, 1'b0},
    '{64'h0000_0000_0040_6004, 2'b00, 2'd3, 1'b0, 28'h0, 4'hF, 1'b1, 2'd2, 41'h0, 1'b0},
    '{64'h0000_0000_0040_6004, 2'b00, 2'd2, 1'b1, 28'h1, 4'b1011, 1'b1, 2'd1, 41'h0, 1'b0},
    '{64'h0000_0000_0040_6006, 2'b00, 2'd2, 1'b1, 28'h8000001, 4'b0100, 1'b1, 2'd0, 41'h100_0000_2004, 1'b1},
    '{64'hFFFF_FFFF_FFFF_E008, 2'b10, 2'd3, 1'b1, 28'h0000001, 4'b1000, 1'b1, 2'd0, 41'h000_0000_2008, 1'b0},
    '{64'hFFFF_F800_0000_0000, 2'b10, 2'd0, 1'b1, 28'h1, 4'hF, 1'b0, 2'd1, 41'h0, 1'b0}
  };
  localparam string TAGS [NV] = '{"R1", "R1", "R2", "R3", "R9", "R4",
                                   "R7", "R5", "R6", "R9", "R7", "R2"};

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] pc, input logic [1:0] sp, input logic [1:0] md,
                       input logic hit, input logic [27:0] pfn, input logic [3:0] xen);
    req_valid = 1'b1; req_pc = pc; sp_en = sp; cur_mode = md;
    tlb_hit = hit; tlb_pfn = pfn; tlb_xen = xen;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_pc = '0; sp_en = 2'b00; cur_mode = 2'd0;
    cur_asn = 8'h5A; ptbase = 64'h0000_0002_0000_0000;
    tlb_hit = 1'b0; tlb_pfn = '0; tlb_xen = '0;
    repeat (3) @(negedge clk);
    chk("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11", "events", 64'({ev_hit, ev_miss, ev_acv}), 64'd0);
    chk("R11", "flt_tag", flt_tag, 64'd0);
    chk("R11", "flt_ptr", flt_ptr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].pc, VECS[i].sp, VECS[i].mode, VECS[i].hit, VECS[i].pfn, VECS[i].xen);
      #1;
      chk(TAGS[i], "tlb_req", 64'(tlb_req), 64'(VECS[i].look));
      @(negedge clk);
      chk(TAGS[i], "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(TAGS[i], "fault", 64'(rsp_fault), 64'(VECS[i].code));
      chk(TAGS[i], "paddr", 64'(rsp_paddr), 64'(VECS[i].pa));
      chk(TAGS[i], "uncached", 64'(rsp_uncached), 64'(VECS[i].unc));
      chk("R10", "events", 64'({ev_hit, ev_acv, ev_miss}),
          64'({VECS[i].code == 2'd0, VECS[i].code == 2'd1, VECS[i].code == 2'd2}));
    end

    // R12: lookup port contents
    apply(64'h0000_0000_0040_6004, 2'b00, 2'd0, 1'b0, 28'h0, 4'h0);
    cur_asn = 8'hC3;
    #1;
    chk("R12", "tlb_vpn", 64'(tlb_vpn), 64'h203);
    chk("R12", "tlb_asn", 64'(tlb_asn), 64'hC3);
    @(negedge clk);
    // R8: miss captured the pc and the pointer
    chk("R8", "flt_tag", flt_tag, 64'h0000_0000_0040_6004);
    chk("R8", "flt_ptr", flt_ptr, 64'h0000_0002_0000_1018);

    // R8: a successful translation leaves the fault registers alone
    apply(64'h0000_0000_0123_4000, 2'b00, 2'd0, 1'b1, 28'h7, 4'b0001);
    @(negedge clk);
    chk("R8", "hold tag", flt_tag, 64'h0000_0000_0040_6004);
    chk("R8", "hold ptr", flt_ptr, 64'h0000_0002_0000_1018);
    chk("R7", "paddr", 64'(rsp_paddr), 64'h0000_0000_0000_E000);

    // R8: access violation captures a new pointer
    apply(64'h0000_0800_0000_6000, 2'b00, 2'd0, 1'b1, 28'h7, 4'hF);
    @(negedge clk);
    chk("R8", "acv tag", flt_tag, 64'h0000_0800_0000_6000);
    chk("R8", "acv ptr", flt_ptr, 64'h0000_0002_0000_0018);

    // R10: idle cycle gives no response and no events
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "idle valid", 64'(rsp_valid), 64'd0);
    chk("R10", "idle events", 64'({ev_hit, ev_miss, ev_acv}), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule